// File: doc/BRIEF.md
# Frame-Synchronous Serial Voice Port

This block moves one fixed-size slot of voice data per frame over a three-wire synchronous serial link. It runs entirely on the serial bit clock. A frame sync at 8 kHz opens a transfer window, which spans one 125 µs frame. Inside that window the port shifts out a parallel transmit word and collects the same number of received bits into a parallel receive word. Bit clocks that arrive after the window closes do nothing until the next frame sync.

The serial output is open-drain. The block never drives a high level. It asserts an output-enable to pull the line low for a zero, and it releases the line for a one. Outside the window, a control input can hold the line low, which lets a sleeping peripheral detect activity and start its clock. When that input is clear, the line is released outside the window. A rate input selects how the bit clock is read: either one bit per clock, or one bit per two clocks for links where the clock runs at twice the data rate.

The parallel words hold four bytes. Byte k sits in bits [8k+7:8k], and the highest byte goes out on the wire first.

Top module: `voice_sport`

## Requirements
- R1: While rst_ni is low, rx_valid_o is 0, rx_data_o is 0 and the window is closed, so dout_oe_o equals force_low_i.
- R2: A DCLK rising edge that samples fsync_i high, where the previous rising edge sampled it low, opens the window. Bit 31 of the latched transmit word is presented right after that edge.
- R3: With rate_2x_i = 0, each further rising edge advances one bit, MSB first, for 32 bits.
- R4: With rate_2x_i = 1, each bit is held for two DCLK cycles, so the window lasts 64 cycles.
- R5: Inside the window, dout_oe_o is 1 exactly when the current bit is 0. dout_o is 0 whenever dout_oe_o is 1.
- R6: din_i is sampled on the last falling edge before each bit ends, MSB first. The rising edge that ends bit 31 updates rx_data_o and raises rx_valid_o for exactly one cycle.
- R7: Bit clocks after the window leave rx_data_o unchanged and keep rx_valid_o at 0.
- R8: Outside the window, dout_oe_o follows force_low_i: 1 pulls the line low, and 0 releases it.
- R9: A new fsync rising edge inside an open window restarts the window at bit 0 and reloads the transmit word.
- R10: tx_data_i is latched only when the window opens. Changes made during the window do not reach the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial bit clock (DCLK) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rate_2x_i | input | 1 | 1: clock runs at twice the bit rate |
| fsync_i | input | 1 | Frame sync, 8 kHz |
| din_i | input | 1 | Serial receive data |
| force_low_i | input | 1 | Hold the line low outside the window |
| tx_data_i | input | 32 | Transmit bytes, byte 3 sent first |
| dout_o | output | 1 | Line data, 0 whenever enable is high |
| dout_oe_o | output | 1 | Open-drain pull-low enable |
| rx_data_o | output | 32 | Received bytes, first byte in [31:24] |
| rx_valid_o | output | 1 | One-cycle strobe at window end |

## Verification
The bench builds the port with its default 32-bit slot. At that size the 32nd-bit boundary, the one-cycle receive strobe and bit-wise transmit patterns are all visible on the ports within a single frame. Table frames cover both clock rates, with the force control both set and clear, and alternating, all-zero and all-one words. Directed runs cover reset, trailing clocks after the window, a mid-window resync and a mid-window change to the transmit word.

// File: rtl/sport_pkg.sv
package sport_pkg;
  typedef enum logic {RATE_1X = 1'b0, RATE_2X = 1'b1} rate_e;
endpackage

// File: rtl/sport_bitctl.sv
module sport_bitctl
  import sport_pkg::*;
#(
  parameter int SLOT_BITS = 32,
  localparam int CNT_W = $clog2(SLOT_BITS)
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  fsync_i,
  input  rate_e rate_i,
  output logic  start_o,
  output logic  shift_o,
  output logic  last_o,
  output logic  active_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOT_BITS - 1);

  logic             fs_q, ph_q, act_q;
  logic [CNT_W-1:0] cnt_q;

  assign start_o  = fsync_i & ~fs_q;
  // bit ends every edge at 1x, every second edge at 2x
  assign shift_o  = act_q & ~start_o & ((rate_i == RATE_2X) ? ph_q : 1'b1);
  assign last_o   = shift_o & (cnt_q == LAST);
  assign active_o = act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fs_q  <= 1'b0;
      ph_q  <= 1'b0;
      act_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      fs_q <= fsync_i;
      if (start_o) begin
        act_q <= 1'b1;
        ph_q  <= 1'b0;
        cnt_q <= '0;
      end else if (act_q) begin
        ph_q <= (rate_i == RATE_2X) ? ~ph_q : 1'b0;
        if (shift_o) begin
          if (cnt_q == LAST) act_q <= 1'b0;
          else               cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sport_shift.sv
module sport_shift #(
  parameter int SLOT_BITS = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 din_i,
  input  logic                 load_i,
  input  logic [SLOT_BITS-1:0] tx_word_i,
  input  logic                 shift_i,
  input  logic                 last_i,
  output logic                 tx_bit_o,
  output logic [SLOT_BITS-1:0] rx_word_o,
  output logic                 rx_valid_o
);
  logic                 din_neg_q;
  logic [SLOT_BITS-1:0] tx_sr_q, rx_sr_q;
  logic [SLOT_BITS-1:0] rx_next;

  assign rx_next  = {rx_sr_q[SLOT_BITS-2:0], din_neg_q};
  assign tx_bit_o = tx_sr_q[SLOT_BITS-1];

  // receive sample on falling edge
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) din_neg_q <= 1'b0;
    else         din_neg_q <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sr_q    <= '1;
      rx_sr_q    <= '0;
      rx_word_o  <= '0;
      rx_valid_o <= 1'b0;
    end else begin
      rx_valid_o <= last_i;
      if (load_i)       tx_sr_q <= tx_word_i;
      else if (shift_i) tx_sr_q <= {tx_sr_q[SLOT_BITS-2:0], 1'b1};
      if (shift_i) rx_sr_q <= rx_next;
      if (last_i)  rx_word_o <= rx_next;
    end
  end
endmodule

// File: rtl/sport_odrv.sv
module sport_odrv (
  input  logic active_i,
  input  logic tx_bit_i,
  input  logic force_low_i,
  output logic dout_o,
  output logic dout_oe_o
);
  always_comb begin
    if (active_i) begin
      dout_oe_o = ~tx_bit_i;
      dout_o    = tx_bit_i;
    end else begin
      dout_oe_o = force_low_i;
      dout_o    = 1'b0;
    end
  end
endmodule

// File: rtl/voice_sport.sv
module voice_sport
  import sport_pkg::*;
#(
  parameter int SLOT_BITS = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rate_2x_i,
  input  logic                 fsync_i,
  input  logic                 din_i,
  input  logic                 force_low_i,
  input  logic [SLOT_BITS-1:0] tx_data_i,
  output logic                 dout_o,
  output logic                 dout_oe_o,
  output logic [SLOT_BITS-1:0] rx_data_o,
  output logic                 rx_valid_o
);
  logic  start, shift, last, win_active, tx_bit;
  rate_e rate;

  assign rate = rate_e'(rate_2x_i);

  sport_bitctl #(.SLOT_BITS(SLOT_BITS)) u_ctl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fsync_i (fsync_i),
    .rate_i  (rate),
    .start_o (start),
    .shift_o (shift),
    .last_o  (last),
    .active_o(win_active)
  );

  sport_shift #(.SLOT_BITS(SLOT_BITS)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .din_i     (din_i),
    .load_i    (start),
    .tx_word_i (tx_data_i),
    .shift_i   (shift),
    .last_i    (last),
    .tx_bit_o  (tx_bit),
    .rx_word_o (rx_data_o),
    .rx_valid_o(rx_valid_o)
  );

  sport_odrv u_drv (
    .active_i   (win_active),
    .tx_bit_i   (tx_bit),
    .force_low_i(force_low_i),
    .dout_o     (dout_o),
    .dout_oe_o  (dout_oe_o)
  );
endmodule

// File: rtl/sport_chk.sv
module sport_chk #(
  parameter int SLOT_BITS = 32
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 fsync_i,
  input logic                 force_low_i,
  input logic                 win_active,
  input logic                 dout_o,
  input logic                 dout_oe_o,
  input logic [SLOT_BITS-1:0] rx_data_o,
  input logic                 rx_valid_o
);
  assert_fs_open_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fsync_i && !$past(fsync_i)) |=> win_active);

  assert_pull_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dout_oe_o |-> !dout_o);

  assert_strobe_one_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  assert_strobe_closed_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> !win_active);

  assert_rx_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_valid_o |-> $stable(rx_data_o));

  assert_force_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_active |-> (dout_oe_o == force_low_i));
endmodule

bind voice_sport sport_chk #(.SLOT_BITS(SLOT_BITS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .fsync_i    (fsync_i),
  .force_low_i(force_low_i),
  .win_active (win_active),
  .dout_o     (dout_o),
  .dout_oe_o  (dout_oe_o),
  .rx_data_o  (rx_data_o),
  .rx_valid_o (rx_valid_o)
);

// File: tb/sim_voice_sport.sv
module sim_voice_sport;
  localparam int CLK_P = 10;
  localparam int W     = 32;
  localparam int NV    = 6;
  // {rate_2x, force, tx, rx}
  localparam logic [65:0] VEC [NV] = '{
    {1'b0, 1'b0, 32'hA5C3_0F81, 32'h1234_5678},
    {1'b0, 1'b1, 32'h0000_0000, 32'hFFFF_FFFF},
    {1'b1, 1'b0, 32'hFFFF_FFFF, 32'h0000_0000},
    {1'b1, 1'b1, 32'h8000_0001, 32'h5555_AAAA},
    {1'b0, 1'b0, 32'h7E81_33CC, 32'h8000_0001},
    {1'b1, 1'b0, 32'hDEAD_BEEF, 32'hC001_D00D}
  };

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          rate_2x = 1'b0, fsync = 1'b0, din = 1'b0, force_low = 1'b0;
  logic [W-1:0]  tx_data = '0;
  logic          dout, dout_oe, rx_valid;
  logic [W-1:0]  rx_data;
  int            n_chk = 0, n_fail = 0;
  bit            done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  voice_sport #(.SLOT_BITS(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .rate_2x_i(rate_2x), .fsync_i(fsync),
    .din_i(din), .force_low_i(force_low), .tx_data_i(tx_data),
    .dout_o(dout), .dout_oe_o(dout_oe), .rx_data_o(rx_data), .rx_valid_o(rx_valid)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  // starts at posedge+2; checks first nbits, full-frame end checks if nbits==W
  task automatic run_frame(input logic [W-1:0] tx, input logic [W-1:0] rx,
                           input logic r2x, input logic frc, input int nbits);
    rate_2x = r2x; force_low = frc; tx_data = tx; fsync = 1'b1;
    step();
    fsync = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      chk(r2x ? "R4" : "R3", {31'd0, dout_oe}, {31'd0, ~tx[W-1-i]});
      if (dout_oe) chk("R5", {31'd0, dout}, 32'd0);
      if (i == 1) tx_data = ~tx; // R10: late change ignored
      din = rx[W-1-i];
      if (r2x) begin
        step();
        chk("R4", {31'd0, dout_oe}, {31'd0, ~tx[W-1-i]});
      end
      step();
      if (i < W - 1) chk("R6", {31'd0, rx_valid}, 32'd0);
    end
    if (nbits == W) begin
      chk("R6", {31'd0, rx_valid}, 32'd1);
      chk("R6", rx_data, rx);
      chk("R8", {31'd0, dout_oe}, {31'd0, frc});
      step();
      chk("R6", {31'd0, rx_valid}, 32'd0);
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog act=running exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    #2;
    chk("R1", {31'd0, rx_valid}, 32'd0);
    chk("R1", rx_data, '0);
    chk("R1", {31'd0, dout_oe}, 32'd0);
    force_low = 1'b1; #1;
    chk("R1", {31'd0, dout_oe}, 32'd1);
    force_low = 1'b0;
    #(CLK_P * 3);
    rst_n = 1'b1;
    step(); step();

    for (int v = 0; v < NV; v++) begin
      logic [65:0] e;
      e = VEC[v];
      run_frame(e[63:32], e[31:0], e[65], e[64], W);
    end

    // R7 trailing clocks ignored, R8 force toggling
    begin
      logic [W-1:0] held;
      held = rx_data;
      for (int c = 0; c < 40; c++) begin
        din = c[0];
        force_low = c[2];
        #1;
        chk("R8", {31'd0, dout_oe}, {31'd0, c[2]});
        step();
        chk("R7", {31'd0, rx_valid}, 32'd0);
      end
      chk("R7", rx_data, held);
    end

    // R9 resync mid-window, then full frame with new word
    run_frame(32'h0F0F_0F0F, 32'hFFFF_0000, 1'b0, 1'b0, 10);
    run_frame(32'h3C3C_A5A5, 32'h0123_4567, 1'b0, 1'b0, W);
    chk("R9", rx_data, 32'h0123_4567);
    run_frame(32'hF0F0_0000, 32'h0000_FFFF, 1'b1, 1'b1, 7);
    run_frame(32'h1357_9BDF, 32'h2468_ACE0, 1'b1, 1'b1, W);
    chk("R9", rx_data, 32'h2468_ACE0);

    // R2 held fsync is one start only: window closes after 32 bits
    rate_2x = 1'b0; force_low = 1'b0; tx_data = 32'h0000_0000; fsync = 1'b1;
    step();
    for (int i = 0; i < W; i++) step();
    chk("R2", {31'd0, rx_valid}, 32'd1);
    step(); step();
    chk("R2", {31'd0, dout_oe}, 32'd0);
    fsync = 1'b0;
    step();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule